// File: doc/BRIEF.md
# Resistive Memory Cell Pulse Sequencer

This controller drives one two-terminal resistive memory cell through a pair of external analog switches. One switch applies a positive drive and the other a negative drive. A third output selects how the sensing node is tied. It is grounded during writes and connected to the read reference supply during reads. The cell's state moves in proportion to the net drive it receives.

A write request produces a single drive pulse. A stored one gets a positive pulse and a stored zero gets a negative pulse. Both use the same width, which is raised to a configured minimum so the state always travels fully to one end.

A read request produces a balanced pair of pulses. The negative phase comes first, then the positive phase, with equal widths, so the net drive is zero and the stored state is left where it was. During the negative phase the external comparator shows the inverse of the stored bit. The controller ignores it there. It captures the comparator on the last cycle of the positive phase and presents the result with a one-cycle strobe.

Top module: `mcell_pulse_seq`

## Requirements
- R1: A write with `wr_data`=1 produces exactly one run of `drive_pos` high, lasting the effective write width in cycles, with `drive_neg` low and `sense_sel`=0 throughout.
- R2: A write with `wr_data`=0 produces exactly one run of `drive_neg` high, of the same effective width, with `drive_pos` low and `sense_sel`=0 throughout.
- R3: The effective write width is the larger of `cfg_wr_width` and `cfg_wr_min`, and a result of 0 counts as 1. The effective read width is `cfg_rd_width`, with 0 counting as 1. Both are taken from the configuration inputs in the cycle the request is accepted.
- R4: A read produces a run of `drive_neg` lasting the read width, then exactly one cycle with both drives low, then a run of `drive_pos` lasting the read width. `sense_sel`=1 holds from the first negative cycle through the last positive cycle.
- R5: The read result `rd_data` equals `cmp_in` as sampled on the last cycle of the positive phase. `rd_valid` is high for exactly the one cycle after it. `cmp_in` during the negative phase has no effect.
- R6: `drive_pos` and `drive_neg` are never high in the same cycle, and a cycle with both low always separates a run of one from a run of the other.
- R7: `busy` is high from the cycle after a request is accepted through the last pulse cycle: W cycles for a write and 2W+1 cycles for a read. A request that arrives while `busy` is high is ignored.
- R8: If `wr_req` and `rd_req` are both high in an accepted cycle, only the write is performed.
- R9: While `rst` is high, the next clock edge leaves `busy`, `drive_pos`, `drive_neg`, `sense_sel` and `rd_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, accepted when not busy |
| wr_data | input | 1 | Bit to write (1 = positive pulse) |
| rd_req | input | 1 | Read request, accepted when not busy and no write request |
| cfg_wr_width | input | CNT_W | Requested write pulse width in cycles |
| cfg_wr_min | input | CNT_W | Minimum write pulse width in cycles |
| cfg_rd_width | input | CNT_W | Width of each read phase in cycles |
| cmp_in | input | 1 | Digital comparator result from the sensing node |
| drive_pos | output | 1 | Positive drive switch enable |
| drive_neg | output | 1 | Negative drive switch enable |
| sense_sel | output | 1 | Sensing node select: 0 ground, 1 read reference |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 1 | Read result bit |

## Verification
Writes of both polarities are issued with a width above the minimum, below it, and with both settings at zero. These cases separate correct clamping from a plain pass-through and from an off-by-one counter. Reads of width one and of width three are run on a cell model whose comparator shows the inverse bit in the negative phase and the true bit in the positive phase. A controller that samples in the wrong phase therefore returns the wrong bit. Reads are also run directly after writes of the opposite value, so a stale result cannot pass. Simultaneous write and read requests, and a read request raised in the middle of a write pulse, confirm the priority and that the dropped request produces no further pulses.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RNEG = 3'd2,
    ST_RGAP = 3'd3,
    ST_RPOS = 3'd4
  } seq_state_t;
endpackage

// File: rtl/mcs_width_calc.sv
// Derives the effective pulse widths: write width clamped up to the minimum,
// and any zero width promoted to one cycle.
module mcs_width_calc #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] wr_width,
  input  logic [CNT_W-1:0] wr_min,
  input  logic [CNT_W-1:0] rd_width,
  output logic [CNT_W-1:0] wr_eff,
  output logic [CNT_W-1:0] rd_eff
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] wr_base;

  always_comb begin
    wr_base = (wr_width < wr_min) ? wr_min : wr_width;
    wr_eff  = (wr_base == '0) ? ONE : wr_base;
    rd_eff  = (rd_width == '0) ? ONE : rd_width;
  end
endmodule

// File: rtl/mcs_phase_timer.sv
// Down counter: load with a width W >= 1; 'last' is high on the W-th cycle.
module mcs_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val - CNT_W'(1);
    else if (cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/mcs_seq_fsm.sv
// Operation sequencer. All outputs are registered from the next state.
module mcs_seq_fsm
  import mcs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             wr_data,
  input  logic             rd_req,
  input  logic [CNT_W-1:0] wr_eff,
  input  logic [CNT_W-1:0] rd_eff,
  input  logic             cmp_in,
  input  logic             last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             drive_pos,
  output logic             drive_neg,
  output logic             sense_sel,
  output logic             busy,
  output logic             rd_valid,
  output logic             rd_data
);
  seq_state_t       st, nxt;
  logic             pol_q, pol_nxt;
  logic [CNT_W-1:0] rd_w_q;
  logic             take_rd;
  logic             rd_done;

  assign take_rd = (st == ST_IDLE) && rd_req && !wr_req;
  assign rd_done = (st == ST_RPOS) && last;
  assign pol_nxt = ((st == ST_IDLE) && wr_req) ? wr_data : pol_q;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = rd_w_q;
    unique case (st)
      ST_IDLE: begin
        if (wr_req) begin
          nxt      = ST_WR;
          tmr_load = 1'b1;
          tmr_val  = wr_eff;
        end else if (rd_req) begin
          nxt      = ST_RNEG;
          tmr_load = 1'b1;
          tmr_val  = rd_eff;
        end
      end
      ST_WR:   if (last) nxt = ST_IDLE;
      ST_RNEG: if (last) nxt = ST_RGAP;
      ST_RGAP: begin
        nxt      = ST_RPOS;
        tmr_load = 1'b1;
        tmr_val  = rd_w_q;
      end
      ST_RPOS: if (last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pol_q     <= 1'b0;
      rd_w_q    <= '0;
      drive_pos <= 1'b0;
      drive_neg <= 1'b0;
      sense_sel <= 1'b0;
      busy      <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= 1'b0;
    end else begin
      st        <= nxt;
      pol_q     <= pol_nxt;
      if (take_rd) rd_w_q <= rd_eff;
      drive_pos <= ((nxt == ST_WR) && pol_nxt) || (nxt == ST_RPOS);
      drive_neg <= ((nxt == ST_WR) && !pol_nxt) || (nxt == ST_RNEG);
      sense_sel <= (nxt == ST_RNEG) || (nxt == ST_RGAP) || (nxt == ST_RPOS);
      busy      <= (nxt != ST_IDLE);
      rd_valid  <= rd_done;
      if (rd_done) rd_data <= cmp_in;
    end
  end
endmodule

// File: rtl/mcell_pulse_seq.sv
module mcell_pulse_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             wr_data,
  input  logic             rd_req,
  input  logic [CNT_W-1:0] cfg_wr_width,
  input  logic [CNT_W-1:0] cfg_wr_min,
  input  logic [CNT_W-1:0] cfg_rd_width,
  input  logic             cmp_in,
  output logic             drive_pos,
  output logic             drive_neg,
  output logic             sense_sel,
  output logic             busy,
  output logic             rd_valid,
  output logic             rd_data
);
  logic [CNT_W-1:0] wr_eff, rd_eff, tmr_val;
  logic             tmr_load, tmr_last;

  mcs_width_calc #(.CNT_W(CNT_W)) u_width (
    .wr_width (cfg_wr_width),
    .wr_min   (cfg_wr_min),
    .rd_width (cfg_rd_width),
    .wr_eff   (wr_eff),
    .rd_eff   (rd_eff)
  );

  mcs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  mcs_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .wr_eff    (wr_eff),
    .rd_eff    (rd_eff),
    .cmp_in    (cmp_in),
    .last      (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .drive_pos (drive_pos),
    .drive_neg (drive_neg),
    .sense_sel (sense_sel),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mcs_seq_checker.sv
module mcs_seq_checker (
  input logic clk,
  input logic rst,
  input logic drive_pos,
  input logic drive_neg,
  input logic sense_sel,
  input logic busy,
  input logic rd_valid
);
  // R6: never both drives at once
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(drive_pos && drive_neg));

  // R6: no direct switch from one polarity to the other
  assert_pos_to_neg_gap_R6: assert property (@(posedge clk) disable iff (rst)
    drive_pos |=> !drive_neg);
  assert_neg_to_pos_gap_R6: assert property (@(posedge clk) disable iff (rst)
    drive_neg |=> !drive_pos);

  // R5: the strobe lasts one cycle and follows the end of a positive phase
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_valid_after_pos_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(drive_pos) && !drive_pos && !busy));

  // R7: any drive activity happens only while busy
  assert_drive_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (drive_pos || drive_neg || sense_sel) |-> busy);

  // R9: reset clears every control output on the next edge
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!busy && !drive_pos && !drive_neg && !sense_sel && !rd_valid));
endmodule

bind mcell_pulse_seq mcs_seq_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .drive_pos (drive_pos),
  .drive_neg (drive_neg),
  .sense_sel (sense_sel),
  .busy      (busy),
  .rd_valid  (rd_valid)
);

// File: tb/sim_mcell_pulse_seq.sv
module sim_mcell_pulse_seq;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_req = 1'b0, wr_data = 1'b0, rd_req = 1'b0;
  logic [CNT_W-1:0] cfg_wr_width = '0, cfg_wr_min = '0, cfg_rd_width = '0;
  logic cmp_in;
  logic drive_pos, drive_neg, sense_sel, busy, rd_valid, rd_data;

  int checks = 0;
  int errors = 0;
  logic cell_bit = 1'b0;

  // expected item: kind 0 = pulse (pol 1 positive / 0 negative, len, sense), kind 1 = read bit
  typedef struct { int kind; int pol; int len; int sense; string req; } exp_t;
  exp_t exp_q[$];

  always #4ns clk = ~clk;

  // comparator model: inverse bit in the negative read phase, true bit in the positive one
  assign cmp_in = drive_neg ? ~cell_bit : (drive_pos ? cell_bit : ~cell_bit);

  mcell_pulse_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .cfg_wr_width(cfg_wr_width), .cfg_wr_min(cfg_wr_min), .cfg_rd_width(cfg_rd_width),
    .cmp_in(cmp_in), .drive_pos(drive_pos), .drive_neg(drive_neg),
    .sense_sel(sense_sel), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_pulse(input int pol, input int len, input int sense, input string req);
    exp_t e;
    e.kind = 0; e.pol = pol; e.len = len; e.sense = sense; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_bit(input int v, input string req);
    exp_t e;
    e.kind = 1; e.pol = v; e.len = 0; e.sense = 0; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic int wmax(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m == 0) ? 1 : m;
  endfunction

  // wait for idle, raise the request for one edge, then measure busy length
  task automatic run_op(input bit w, input bit r, input bit d, input int bl, input string req);
    int n;
    while (busy) @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    @(negedge clk);
    wr_req = 0; rd_req = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == bl, req, "busy length", n, bl);
    @(negedge clk);
  endtask

  task automatic do_write(input bit d, input int w, input int m, input string req);
    cfg_wr_width = CNT_W'(w); cfg_wr_min = CNT_W'(m);
    push_pulse(d, wmax(w, m), 0, req);
    run_op(1, 0, d, wmax(w, m), req);
    cell_bit = d;
  endtask

  task automatic do_read(input int w, input string req);
    int e;
    e = wmax(w, 0);
    cfg_rd_width = CNT_W'(w);
    push_pulse(0, e, 1, "R4");
    push_pulse(1, e, 1, "R4");
    push_bit(cell_bit, req);
    run_op(0, 1, 0, 2 * e + 1, req);
  endtask

  // monitor: turns pulse runs and strobes into observed items and compares them
  int pos_len = 0, neg_len = 0;
  bit pos_s1 = 1, pos_s0 = 1, neg_s1 = 1, neg_s0 = 1;
  logic prev_pos = 0, prev_neg = 0;

  task automatic observe(input int kind, input int pol, input int len, input bit s1, input bit s0);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(0, "R7", "unexpected item kind/pol", kind * 2 + pol, -1);
      return;
    end
    e = exp_q.pop_front();
    check(kind == e.kind, e.req, "item kind", kind, e.kind);
    check(pol == e.pol, e.req, kind ? "read bit" : "polarity", pol, e.pol);
    if (kind == 0) begin
      check(len == e.len, e.req, "pulse length", len, e.len);
      check(e.sense ? s1 : s0, e.req, "sense_sel during pulse", e.sense ? !s1 : !s0, e.sense);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (drive_pos && drive_neg) check(0, "R6", "overlap", 1, 0);
      if ((prev_pos && drive_neg) || (prev_neg && drive_pos)) check(0, "R6", "no dead cycle", 1, 0);
      if (prev_pos && !drive_pos) begin observe(0, 1, pos_len, pos_s1, pos_s0); pos_len = 0; pos_s1 = 1; pos_s0 = 1; end
      if (prev_neg && !drive_neg) begin observe(0, 0, neg_len, neg_s1, neg_s0); neg_len = 0; neg_s1 = 1; neg_s0 = 1; end
      if (drive_pos) begin pos_len++; pos_s1 &= sense_sel; pos_s0 &= !sense_sel; end
      if (drive_neg) begin neg_len++; neg_s1 &= sense_sel; neg_s0 &= !sense_sel; end
      if (rd_valid) observe(1, int'(rd_data), 0, 1, 1);
      prev_pos = drive_pos; prev_neg = drive_neg;
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !drive_pos && !drive_neg && !sense_sel && !rd_valid, "R9",
          "outputs in reset", int'({busy, drive_pos, drive_neg, sense_sel, rd_valid}), 0);
    rst = 0;
    @(negedge clk);

    do_write(1, 5, 3, "R1");          // width above minimum
    do_read(3, "R5");                 // stored one
    do_write(0, 2, 4, "R3");          // clamped up to minimum, negative (R2)
    do_read(1, "R5");                 // stored zero, phase width one
    do_write(1, 0, 0, "R3");          // zero widths -> one cycle
    do_read(0, "R3");                 // zero read width -> one cycle
    do_write(0, 4, 4, "R2");
    do_read(2, "R4");

    // R8: both requests together, write wins
    cfg_wr_width = 16'd3; cfg_wr_min = 16'd1; cfg_rd_width = 16'd2;
    push_pulse(1, 3, 0, "R8");
    run_op(1, 1, 1, 3, "R8");
    cell_bit = 1;

    // R7: read request raised mid-write is ignored
    cfg_wr_width = 16'd6; cfg_wr_min = 16'd1;
    push_pulse(0, 6, 0, "R7");
    wr_req = 1; wr_data = 0;
    @(negedge clk);
    wr_req = 0;
    @(negedge clk);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    while (busy) @(negedge clk);
    cell_bit = 0;
    repeat (10) @(negedge clk);
    check(!busy, "R7", "stays idle after ignored request", int'(busy), 0);

    do_read(4, "R5");
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7", "outstanding expected items", exp_q.size(), 0);
    finish_run();
  end
endmodule